// File: doc/BRIEF.md
# Hardware Thread Select Unit

This unit sits at the thread-select stage of a single-issue, in-order pipeline that carries four hardware threads, each with its own program counter and instruction buffer. In every clock cycle it decides which thread, if any, sends an instruction on to decode. Its inputs are one bit per thread for each of the following: a non-empty instruction buffer, a pending trap or interrupt, a first-level cache miss, a second-level (costly) cache miss, a resource conflict and a long-latency operation. Its outputs are the chosen thread number, an issue strobe and a flush request.

There are two modes. Fine-grain mode interleaves the threads round-robin, so the issuing thread can change on every cycle and stalled threads are passed over. Coarse-grain mode stays on one thread. It leaves that thread only when the thread takes a second-level miss. It then asks for a pipeline flush and waits out a fixed refill time before the new thread issues. The unit also reports a ranked stall cause for the thread it selected most recently.

Top module: `thread_sel_unit`

## Requirements
- R1: While `rst` is high, `issue_vld_o`, `flush_o`, `sel_tid_o` and `hold_cause_o` are 0. After reset the unit is in fine-grain mode, and the first thread to issue is thread 0 when it is ready.
- R2: A thread is ready only when its buffer-valid bit is 1 and its trap, cache-miss, second-level-miss, conflict and long-op bits are all 0. `issue_vld_o` is never high for a thread that is not ready.
- R3: In fine-grain mode the unit issues the first ready thread, searching upward from the thread after the last selected one and wrapping from 3 to 0. Unready threads are skipped.
- R4: In fine-grain mode, when no thread is ready, `issue_vld_o` is 0, `sel_tid_o` keeps the last selected thread, and the next search starts from the same place.
- R5: In coarse-grain mode the current thread issues on every cycle it is ready, even when other threads are ready too.
- R6: In coarse-grain mode, when the current thread is stalled without a second-level miss, `issue_vld_o` is 0, `flush_o` is 0 and the current thread is kept.
- R7: In coarse-grain mode, when the current thread has a second-level miss and another thread is ready, `flush_o` is high for one cycle with `issue_vld_o` low, and `sel_tid_o` shows the new thread, found by the same round-robin search as R3.
- R8: After a flush, `issue_vld_o` stays low for exactly two more cycles with `sel_tid_o` unchanged. The new thread may issue on the third cycle after the flush.
- R9: In coarse-grain mode, when the current thread has a second-level miss and no other thread is ready, no flush is raised, `issue_vld_o` is 0 and the current thread is kept.
- R10: A change on `coarse_mode_i` takes effect on the cycle after it is seen, but only if the current cycle has no flush and no refill. Otherwise the change waits until the refill is over.
- R11: `hold_cause_o` gives the highest-ranked stall cause of the most recently selected thread. The codes are: trap 1, second-level miss 2, cache miss 3, conflict 4, long-op 5, empty buffer 6, none 0. A lower nonzero code wins.
- R12: `flush_o` is never high in fine-grain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_mode_i | input | 1 | 1 selects coarse-grain, 0 selects fine-grain |
| ibuf_valid_i | input | 4 | Per-thread instruction buffer holds an instruction |
| trap_i | input | 4 | Per-thread pending trap or interrupt |
| dmiss_i | input | 4 | Per-thread first-level cache miss |
| l2_miss_i | input | 4 | Per-thread second-level miss (costly stall) |
| res_conflict_i | input | 4 | Per-thread resource conflict |
| long_op_i | input | 4 | Per-thread long-latency operation in progress |
| sel_tid_o | output | 2 | Issuing thread, flush target, or held thread |
| issue_vld_o | output | 1 | An instruction of `sel_tid_o` goes to decode |
| flush_o | output | 1 | Flush and refill request on a coarse-grain switch |
| hold_cause_o | output | 3 | Ranked stall cause of the last selected thread |

## Verification
A costly miss on the held thread can arrive in the same cycle that the mode input flips back to fine-grain. The bench does this on purpose: it raises the second-level miss and drops `coarse_mode_i` together. It then expects the flush, both refill cycles, and one more issue from the new thread under coarse rules before round-robin interleaving starts again. If the mode change were taken during the flush or the refill, the extra coarse-mode issue would be replaced by a different thread, and the directed checks on `sel_tid_o` would flag it.

// File: rtl/thrsel_pkg.sv
package thrsel_pkg;

    // Ranked stall cause; a lower nonzero code has higher priority
    typedef enum logic [2:0] {
        CZ_NONE     = 3'd0,
        CZ_TRAP     = 3'd1,
        CZ_L2       = 3'd2,
        CZ_MISS     = 3'd3,
        CZ_CONFLICT = 3'd4,
        CZ_LONGOP   = 3'd5,
        CZ_EMPTY    = 3'd6
    } cause_e;

    typedef struct packed {
        logic has_instr;
        logic trap;
        logic l2;
        logic miss;
        logic conflict;
        logic longop;
    } thr_stat_t;

    function automatic cause_e rank_cause(input thr_stat_t s);
        if (s.trap)           return CZ_TRAP;
        else if (s.l2)        return CZ_L2;
        else if (s.miss)      return CZ_MISS;
        else if (s.conflict)  return CZ_CONFLICT;
        else if (s.longop)    return CZ_LONGOP;
        else if (!s.has_instr) return CZ_EMPTY;
        return CZ_NONE;
    endfunction

endpackage

// File: rtl/thrsel_ready.sv
module thrsel_ready
    import thrsel_pkg::*;
#(
    parameter int THR_N = 4
) (
    input  logic [THR_N-1:0] ibuf_valid,
    input  logic [THR_N-1:0] trap,
    input  logic [THR_N-1:0] dmiss,
    input  logic [THR_N-1:0] l2_miss,
    input  logic [THR_N-1:0] conflict,
    input  logic [THR_N-1:0] long_op,
    output logic [THR_N-1:0] ready,
    output cause_e           cause [THR_N]
);

    for (genvar t = 0; t < THR_N; t++) begin : g_thr
        thr_stat_t st;
        always_comb begin
            st.has_instr = ibuf_valid[t];
            st.trap      = trap[t];
            st.l2        = l2_miss[t];
            st.miss      = dmiss[t];
            st.conflict  = conflict[t];
            st.longop    = long_op[t];
        end
        assign cause[t] = rank_cause(st);
        assign ready[t] = (rank_cause(st) == CZ_NONE);
    end

endmodule

// File: rtl/thrsel_rr.sv
module thrsel_rr #(
    parameter int THR_N = 4,
    localparam int TW   = $clog2(THR_N)
) (
    input  logic [THR_N-1:0] req,
    input  logic [TW-1:0]    last,
    output logic [TW-1:0]    pick,
    output logic             found
);

    // THR_N must be a power of two so the index wraps naturally
    logic [TW-1:0] idx;

    always_comb begin
        pick  = last;
        found = 1'b0;
        idx   = last;
        for (int i = 1; i <= THR_N; i++) begin
            idx = last + TW'(i);
            if (!found && req[idx]) begin
                pick  = idx;
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/thread_sel_unit.sv
module thread_sel_unit
    import thrsel_pkg::*;
#(
    parameter int THR_N      = 4,
    parameter int REFILL_CYC = 2,
    localparam int TW        = $clog2(THR_N),
    localparam int CW        = $clog2(REFILL_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             coarse_mode_i,
    input  logic [THR_N-1:0] ibuf_valid_i,
    input  logic [THR_N-1:0] trap_i,
    input  logic [THR_N-1:0] dmiss_i,
    input  logic [THR_N-1:0] l2_miss_i,
    input  logic [THR_N-1:0] res_conflict_i,
    input  logic [THR_N-1:0] long_op_i,
    output logic [TW-1:0]    sel_tid_o,
    output logic             issue_vld_o,
    output logic             flush_o,
    output logic [2:0]       hold_cause_o
);

    logic [TW-1:0]    last_q, nxt_last;
    logic             mode_q;
    logic [CW-1:0]    refill_q;
    logic [THR_N-1:0] ready;
    cause_e           cause [THR_N];
    logic [TW-1:0]    rr_pick;
    logic             rr_found;
    logic             vld, fl;

    thrsel_ready #(.THR_N(THR_N)) u_ready (
        .ibuf_valid (ibuf_valid_i),
        .trap       (trap_i),
        .dmiss      (dmiss_i),
        .l2_miss    (l2_miss_i),
        .conflict   (res_conflict_i),
        .long_op    (long_op_i),
        .ready      (ready),
        .cause      (cause)
    );

    // One search serves both modes: a thread with a costly miss is never ready
    thrsel_rr #(.THR_N(THR_N)) u_rr (
        .req   (ready),
        .last  (last_q),
        .pick  (rr_pick),
        .found (rr_found)
    );

    always_comb begin
        nxt_last = last_q;
        vld      = 1'b0;
        fl       = 1'b0;
        if (rst) begin
            nxt_last = last_q;
        end else if (!mode_q) begin
            if (rr_found) begin
                vld      = 1'b1;
                nxt_last = rr_pick;
            end
        end else if (refill_q != '0) begin
            vld = 1'b0;
        end else if (ready[last_q]) begin
            vld = 1'b1;
        end else if (l2_miss_i[last_q] && rr_found) begin
            fl       = 1'b1;
            nxt_last = rr_pick;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= TW'(THR_N - 1);
            mode_q   <= 1'b0;
            refill_q <= '0;
        end else begin
            last_q <= nxt_last;
            if (fl)
                refill_q <= CW'(REFILL_CYC);
            else if (refill_q != '0)
                refill_q <= refill_q - 1'b1;
            if (refill_q == '0 && !fl)
                mode_q <= coarse_mode_i;
        end
    end

    assign issue_vld_o  = vld;
    assign flush_o      = fl;
    assign sel_tid_o    = rst ? '0 : nxt_last;
    assign hold_cause_o = rst ? 3'(CZ_NONE) : 3'(cause[last_q]);

endmodule

// File: rtl/thrsel_chk.sv
module thrsel_chk #(
    parameter int THR_N = 4,
    localparam int TW   = $clog2(THR_N)
) (
    input logic             clk,
    input logic             rst,
    input logic [THR_N-1:0] ibuf_valid_i,
    input logic [THR_N-1:0] trap_i,
    input logic [THR_N-1:0] dmiss_i,
    input logic [THR_N-1:0] l2_miss_i,
    input logic [THR_N-1:0] res_conflict_i,
    input logic [THR_N-1:0] long_op_i,
    input logic [TW-1:0]    sel_tid_o,
    input logic             issue_vld_o,
    input logic             flush_o,
    input logic             mode_q,
    input logic             refill_q_busy
);

    // R2: an issued thread meets every readiness condition
    p_issue_ready_r2: assert property (@(posedge clk) disable iff (rst)
        issue_vld_o |-> (ibuf_valid_i[sel_tid_o] && !trap_i[sel_tid_o] &&
                         !dmiss_i[sel_tid_o] && !l2_miss_i[sel_tid_o] &&
                         !res_conflict_i[sel_tid_o] && !long_op_i[sel_tid_o]));

    // R7: flush and issue never share a cycle
    p_flush_no_issue_r7: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> !issue_vld_o);

    // R8: first refill cycle is silent and holds the target
    p_refill_first_r8: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> (!issue_vld_o && !flush_o && $stable(sel_tid_o)));

    // R8: second refill cycle is silent too
    p_refill_second_r8: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> ##1 (!issue_vld_o && !flush_o));

    // R12: fine-grain mode never flushes
    p_fine_no_flush_r12: assert property (@(posedge clk) disable iff (rst)
        !mode_q |-> !flush_o);

    // R10: the mode is frozen while a refill is in progress
    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (refill_q_busy || flush_o) |=> $stable(mode_q));

endmodule

bind thread_sel_unit thrsel_chk #(.THR_N(THR_N)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .ibuf_valid_i   (ibuf_valid_i),
    .trap_i         (trap_i),
    .dmiss_i        (dmiss_i),
    .l2_miss_i      (l2_miss_i),
    .res_conflict_i (res_conflict_i),
    .long_op_i      (long_op_i),
    .sel_tid_o      (sel_tid_o),
    .issue_vld_o    (issue_vld_o),
    .flush_o        (flush_o),
    .mode_q         (mode_q),
    .refill_q_busy  (refill_q != '0)
);

// File: tb/thread_sel_unit_tb_top.sv
module thread_sel_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coarse_mode_i = 1'b0;
    logic [3:0] ibuf_valid_i = '0, trap_i = '0, dmiss_i = '0;
    logic [3:0] l2_miss_i = '0, res_conflict_i = '0, long_op_i = '0;
    logic [1:0] sel_tid_o;
    logic       issue_vld_o, flush_o;
    logic [2:0] hold_cause_o;

    int nchk = 0;
    int nbad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    thread_sel_unit dut_i (
        .clk            (clk),
        .rst            (rst),
        .coarse_mode_i  (coarse_mode_i),
        .ibuf_valid_i   (ibuf_valid_i),
        .trap_i         (trap_i),
        .dmiss_i        (dmiss_i),
        .l2_miss_i      (l2_miss_i),
        .res_conflict_i (res_conflict_i),
        .long_op_i      (long_op_i),
        .sel_tid_o      (sel_tid_o),
        .issue_vld_o    (issue_vld_o),
        .flush_o        (flush_o),
        .hold_cause_o   (hold_cause_o)
    );

    // Fine-grain vectors: [31:28] buf [27:24] trap [23:20] miss
    // [19:16] conflict [15:12] long-op [11:8] l2 [4] exp vld [1:0] exp tid
    localparam logic [31:0] VEC [9] = '{
        32'hF000_0010,  // R1 first issue is thread 0
        32'hF000_0011,  // R3 rotate
        32'hF000_0012,  // R3 rotate
        32'hF800_0010,  // R3 skip trapped thread 3, wrap
        32'hB020_0013,  // R3 skip missed 1, empty 2
        32'hF001_2812,  // R2 only thread 2 ready; R12 l2 miss gives no flush
        32'h0000_0002,  // R4 nothing ready, hold 2
        32'hF000_0013,  // R4 pointer did not move
        32'hF000_0010   // R3 wrap
    };

    task automatic drive(input logic [3:0] b, tr, dm, cf, lo, l2, input logic md);
        @(negedge clk);
        rst            = 1'b0;
        ibuf_valid_i   = b;
        trap_i         = tr;
        dmiss_i        = dm;
        res_conflict_i = cf;
        long_op_i      = lo;
        l2_miss_i      = l2;
        coarse_mode_i  = md;
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk3(input string tag, input int v, input int f, input int t);
        chk({tag, " vld"},   int'(issue_vld_o), v);
        chk({tag, " flush"}, int'(flush_o), f);
        chk({tag, " tid"},   int'(sel_tid_o), t);
    endtask

    initial begin
        #(8 * 20000);
        nchk++;
        nbad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        // R1: reset state with every thread ready
        drive(4'hF, 0, 0, 0, 0, 0, 1'b0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 reset vld", int'(issue_vld_o), 0);
        chk("R1 reset flush", int'(flush_o), 0);
        chk("R1 reset tid", int'(sel_tid_o), 0);
        chk("R1 reset cause", int'(hold_cause_o), 0);

        for (int i = 0; i < 9; i++) begin
            drive(VEC[i][31:28], VEC[i][27:24], VEC[i][23:20], VEC[i][19:16],
                  VEC[i][15:12], VEC[i][11:8], 1'b0);
            chk3($sformatf("R3 fine row %0d", i), int'(VEC[i][4]), 0, int'(VEC[i][1:0]));
        end

        // Coarse-grain directed sequence; mode is requested during reset
        drive(4'hF, 0, 0, 0, 0, 0, 1'b1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        drive(4'hF, 0, 0, 0, 0, 0, 1'b1);
        chk3("R1 first after reset", 1, 0, 0);       // still fine mode this cycle
        drive(4'hF, 0, 0, 0, 0, 0, 1'b1);
        chk3("R5 coarse hold a", 1, 0, 0);
        drive(4'hF, 0, 0, 0, 0, 0, 1'b1);
        chk3("R5 coarse hold b", 1, 0, 0);
        drive(4'hF, 0, 4'h1, 0, 0, 0, 1'b1);
        chk3("R6 short stall", 0, 0, 0);
        chk("R11 cause miss", int'(hold_cause_o), 3);
        // costly miss and mode drop in the same cycle
        drive(4'hF, 0, 0, 0, 0, 4'h1, 1'b0);
        chk3("R7 switch flush", 0, 1, 1);
        drive(4'hF, 0, 0, 0, 0, 0, 1'b0);
        chk3("R8 refill 1", 0, 0, 1);
        drive(4'hF, 0, 0, 0, 0, 0, 1'b0);
        chk3("R8 refill 2", 0, 0, 1);
        drive(4'hF, 0, 0, 0, 0, 0, 1'b0);
        chk3("R8 R10 first issue still coarse", 1, 0, 1);
        drive(4'hF, 0, 0, 0, 0, 0, 1'b0);
        chk3("R10 fine resumes", 1, 0, 2);
        drive(4'hF, 0, 0, 0, 0, 0, 1'b1);
        chk3("R10 fine before change", 1, 0, 3);
        // coarse now, current thread 3
        drive(4'h8, 0, 0, 0, 4'h8, 4'h8, 1'b1);
        chk3("R9 miss no target", 0, 0, 3);
        chk("R11 cause l2 over longop", int'(hold_cause_o), 2);
        drive(4'hF, 4'h8, 4'h8, 0, 0, 0, 1'b1);
        chk3("R6 trap no switch", 0, 0, 3);
        chk("R11 cause trap over miss", int'(hold_cause_o), 1);
        drive(4'h7, 0, 0, 4'h8, 0, 0, 1'b1);
        chk("R11 cause conflict", int'(hold_cause_o), 4);
        drive(4'h7, 0, 0, 0, 0, 0, 1'b1);
        chk("R11 cause empty", int'(hold_cause_o), 6);
        chk3("R6 empty buffer no switch", 0, 0, 3);
        drive(4'hF, 0, 0, 0, 0, 0, 1'b1);
        chk3("R5 resume", 1, 0, 3);
        chk("R11 cause none", int'(hold_cause_o), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule